// File: doc/BRIEF.md
# Quad Two-Input Gate Tester Sequencer

This block is a small controller that decides whether an external quad two-input NAND device works. A single start pulse makes it walk through four fixed stimulus patterns. For each pattern it drives the eight gate inputs and then waits a settle interval that software can set. After the wait it samples the four gate outputs through a synchronizer and compares them with the response a healthy NAND device would give. The upper bits of the response bus are cleared before the compare, so they cannot affect it.

The first mismatch ends the run, and the remaining patterns are never driven. If all four patterns match, the run ends with a pass. The verdict appears as a two-bit lamp code and stays there until the next start. A busy flag covers the whole run, and a one-cycle done strobe marks the moment the verdict is latched.

Top module: `quad_gate_checker`

## Requirements
- R1: While reset is held and in the first cycle after it, lamp_o is 2'b00, busy_o and done_o are 0, and stim_o is 8'h00.
- R2: Patterns are driven in the order 8'h00, 8'h55, 8'hAA, 8'hFF. Pattern k puts pair code k on every gate, where gate g takes input A on stim_o[2g] and input B on stim_o[2g+1]. After a verdict, stim_o still holds the last pattern that was driven.
- R3: Each pattern takes W+2 cycles, where W is settle_i but at least 2. The response is sampled through a two-flop synchronizer, so a device output that settles within one cycle of the stimulus is judged correctly.
- R4: Only resp_i[3:0] is compared, with resp_i[g] being the output of gate g. The expected nibbles are 4'hF, 4'hF, 4'hF and 4'h0 for the four patterns, and resp_i[7:4] has no effect.
- R5: When all four patterns match, lamp_o becomes 2'b01 at clock edge S+4(W+2), where S is the edge that samples start_i.
- R6: When pattern k (0-based) is the first to mismatch, lamp_o becomes 2'b10 at edge S+(k+1)(W+2), and no later pattern is driven.
- R7: lamp_o is 2'b00 while a run is in progress. A new start clears the previous verdict at edge S.
- R8: busy_o is 1 from edge S until the verdict edge. done_o is 1 for exactly the one cycle after the verdict edge, and busy_o is 0 in that cycle.
- R9: A start_i pulse that arrives while busy_o is 1 is ignored and does not change the timing or the verdict.
- R10: After a verdict, lamp_o, stim_o and busy_o hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a test run when not busy |
| settle_i | input | 8 | Settle cycles per pattern (values below 2 are raised to 2) |
| resp_i | input | 8 | Device outputs; only [3:0] are used |
| stim_o | output | 8 | Gate input drive, two bits per gate |
| lamp_o | output | 2 | 00 off, 01 pass, 10 fail |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle strobe when the verdict is latched |

## Verification
Every result is timed from the edge that samples start_i. busy_o and the cleared lamp are due at that edge. The verdict and the done strobe are due n(W+2) edges later, where n is the number of patterns driven before the run stopped. The driver records the cycle counter when it raises start_i and queues the lamp code, the latency 1+n(W+2) measured at the falling edge, and the final stimulus byte. The monitor samples on falling edges and compares each queued item on the cycle done_o is seen, so an early or late verdict shows up as a latency error rather than being missed.

// File: rtl/qgc_pkg.sv
package qgc_pkg;

   // sequencer states
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_APPLY  = 3'd1,
      ST_SETTLE = 3'd2,
      ST_CHECK  = 3'd3,
      ST_HALT   = 3'd4
   } seq_state_e;

   // lamp codes, one-hot when lit
   localparam logic [1:0] LAMP_OFF  = 2'b00;
   localparam logic [1:0] LAMP_PASS = 2'b01;
   localparam logic [1:0] LAMP_FAIL = 2'b10;

   // a two-input gate has four input pair codes; one pattern per code
   localparam int unsigned PAIR_W    = 2;
   localparam int unsigned VEC_COUNT = 1 << PAIR_W;
   localparam int unsigned VEC_IDX_W = PAIR_W;
   localparam int unsigned LEFT_W    = $clog2(VEC_COUNT + 1);

endpackage

// File: rtl/qgc_vec_rom.sv
module qgc_vec_rom
   import qgc_pkg::*;
#(
   parameter int unsigned N_GATES = 4
) (
   input  logic [VEC_IDX_W-1:0]        idx_i,
   output logic [PAIR_W*N_GATES-1:0]   stim_o,
   output logic [N_GATES-1:0]          expect_o
);

   // pattern k applies pair code k to every gate; a NAND yields 0 only for code 2'b11
   for (genvar g = 0; g < N_GATES; g++) begin : g_gate
      assign stim_o[PAIR_W*g +: PAIR_W] = idx_i;
      assign expect_o[g]                = ~(&idx_i);
   end

endmodule

// File: rtl/qgc_sync.sv
module qgc_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stg_q[0] <= '0;
            else         stg_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stg_q[s] <= '0;
            else         stg_q[s] <= stg_q[s-1];
         end
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/qgc_cmp.sv
module qgc_cmp #(
   parameter int unsigned RESP_W = 8,
   parameter int unsigned CMP_W  = 4
) (
   input  logic [RESP_W-1:0] resp_i,
   input  logic [CMP_W-1:0]  expect_i,
   output logic              match_o
);

   logic [RESP_W-1:0] masked;
   logic [RESP_W-1:0] golden;

   if (RESP_W == CMP_W) begin : g_full
      assign masked = resp_i;
      assign golden = expect_i;
   end else begin : g_mask
      localparam logic [RESP_W-1:0] KEEP = {{(RESP_W-CMP_W){1'b0}}, {CMP_W{1'b1}}};
      assign masked = resp_i & KEEP;
      assign golden = {{(RESP_W-CMP_W){1'b0}}, expect_i};
   end

   assign match_o = (masked == golden);

endmodule

// File: rtl/qgc_seq.sv
module qgc_seq
   import qgc_pkg::*;
#(
   parameter int unsigned N_GATES    = 4,
   parameter int unsigned CNT_W      = 8,
   parameter int unsigned MIN_SETTLE = 2
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      start_i,
   input  logic [CNT_W-1:0]          settle_i,
   input  logic                      match_i,
   input  logic [PAIR_W*N_GATES-1:0] rom_stim_i,
   output logic [VEC_IDX_W-1:0]      idx_o,
   output logic [PAIR_W*N_GATES-1:0] stim_o,
   output logic [1:0]                lamp_o,
   output logic                      busy_o,
   output logic                      done_o
);

   localparam int unsigned STIM_W = PAIR_W * N_GATES;
   localparam logic [CNT_W-1:0] MIN_W = CNT_W'(MIN_SETTLE);

   seq_state_e             state_q;
   logic [VEC_IDX_W-1:0]   idx_q;
   logic [LEFT_W-1:0]      left_q;
   logic [CNT_W-1:0]       wait_q;
   logic [STIM_W-1:0]      stim_q;
   logic [1:0]             lamp_q;
   logic                   done_q;
   logic [CNT_W-1:0]       eff_wait;
   logic                   take_start;

   assign eff_wait   = (settle_i < MIN_W) ? MIN_W : settle_i;
   assign take_start = start_i && (state_q == ST_IDLE || state_q == ST_HALT);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         left_q  <= '0;
         wait_q  <= '0;
         stim_q  <= '0;
         lamp_q  <= LAMP_OFF;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE, ST_HALT: begin
               if (take_start) begin
                  idx_q   <= '0;
                  left_q  <= LEFT_W'(VEC_COUNT);
                  lamp_q  <= LAMP_OFF;
                  state_q <= ST_APPLY;
               end
            end
            ST_APPLY: begin
               stim_q  <= rom_stim_i;
               wait_q  <= eff_wait - 1'b1;
               state_q <= ST_SETTLE;
            end
            ST_SETTLE: begin
               if (wait_q == '0) state_q <= ST_CHECK;
               else              wait_q  <= wait_q - 1'b1;
            end
            ST_CHECK: begin
               if (!match_i) begin
                  lamp_q  <= LAMP_FAIL;
                  done_q  <= 1'b1;
                  state_q <= ST_HALT;
               end else if (left_q == LEFT_W'(1)) begin
                  lamp_q  <= LAMP_PASS;
                  done_q  <= 1'b1;
                  state_q <= ST_HALT;
               end else begin
                  idx_q   <= idx_q + 1'b1;
                  left_q  <= left_q - 1'b1;
                  state_q <= ST_APPLY;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign idx_o  = idx_q;
   assign stim_o = stim_q;
   assign lamp_o = lamp_q;
   assign busy_o = (state_q != ST_IDLE) && (state_q != ST_HALT);
   assign done_o = done_q;

endmodule

// File: rtl/quad_gate_checker.sv
module quad_gate_checker
   import qgc_pkg::*;
#(
   parameter int unsigned N_GATES     = 4,
   parameter int unsigned RESP_W      = 8,
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned MIN_SETTLE  = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      start_i,
   input  logic [CNT_W-1:0]          settle_i,
   input  logic [RESP_W-1:0]         resp_i,
   output logic [PAIR_W*N_GATES-1:0] stim_o,
   output logic [1:0]                lamp_o,
   output logic                      busy_o,
   output logic                      done_o
);

   localparam int unsigned STIM_W = PAIR_W * N_GATES;

   // elaboration-time parameter checks
   if (N_GATES < 1) begin : g_bad_gates
      $error("quad_gate_checker: N_GATES must be at least 1");
   end
   if (RESP_W < N_GATES) begin : g_bad_resp
      $error("quad_gate_checker: RESP_W narrower than gate count");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("quad_gate_checker: SYNC_STAGES must be at least 2");
   end
   if (MIN_SETTLE < SYNC_STAGES) begin : g_bad_settle
      $error("quad_gate_checker: MIN_SETTLE must cover synchronizer depth");
   end
   if (CNT_W < $clog2(MIN_SETTLE + 1)) begin : g_bad_cnt
      $error("quad_gate_checker: CNT_W cannot hold MIN_SETTLE");
   end

   logic [VEC_IDX_W-1:0] idx;
   logic [STIM_W-1:0]    rom_stim;
   logic [N_GATES-1:0]   rom_expect;
   logic [RESP_W-1:0]    resp_sync;
   logic                 match;

   qgc_vec_rom #(.N_GATES(N_GATES)) u_rom (
      .idx_i    (idx),
      .stim_o   (rom_stim),
      .expect_o (rom_expect)
   );

   qgc_sync #(.WIDTH(RESP_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (resp_i),
      .q_o    (resp_sync)
   );

   qgc_cmp #(.RESP_W(RESP_W), .CMP_W(N_GATES)) u_cmp (
      .resp_i   (resp_sync),
      .expect_i (rom_expect),
      .match_o  (match)
   );

   qgc_seq #(.N_GATES(N_GATES), .CNT_W(CNT_W), .MIN_SETTLE(MIN_SETTLE)) u_seq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (start_i),
      .settle_i   (settle_i),
      .match_i    (match),
      .rom_stim_i (rom_stim),
      .idx_o      (idx),
      .stim_o     (stim_o),
      .lamp_o     (lamp_o),
      .busy_o     (busy_o),
      .done_o     (done_o)
   );

endmodule

// File: rtl/qgc_chk.sv
module qgc_chk #(
   parameter int unsigned STIM_W = 8,
   parameter int unsigned N_GATES = 4
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              start_i,
   input logic [STIM_W-1:0] stim_o,
   input logic [1:0]        lamp_o,
   input logic              busy_o,
   input logic              done_o
);

   AST_STIM_PATTERN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stim_o == {N_GATES{stim_o[1:0]}}) else $error("stim not uniform");   // R2

   AST_LAMP_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(lamp_o)) else $error("lamp code illegal");                  // R6

   AST_LAMP_DARK_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |-> lamp_o == 2'b00) else $error("lamp lit while busy");      // R7

   AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o) else $error("done longer than one cycle");       // R8

   AST_DONE_VERDICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (!busy_o && lamp_o != 2'b00)) else $error("done without verdict"); // R8

   AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !busy_o) |=> busy_o) else $error("start not taken");     // R8

   AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && !done_o && lamp_o == 2'b00) |=> (busy_o || done_o)) else $error("busy dropped without verdict"); // R9

   AST_VERDICT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && !start_i) |=> ($stable(lamp_o) && $stable(stim_o))) else $error("verdict moved"); // R10

endmodule

bind quad_gate_checker qgc_chk #(.STIM_W(STIM_W), .N_GATES(N_GATES)) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .start_i (start_i),
   .stim_o  (stim_o),
   .lamp_o  (lamp_o),
   .busy_o  (busy_o),
   .done_o  (done_o)
);

// File: tb/sim_quad_gate_checker.sv
`timescale 1ns/1ps
module sim_quad_gate_checker;

   localparam int NG = 4;
   localparam int RW = 8;
   localparam int CW = 8;
   localparam int SW = 2 * NG;

   typedef struct {
      logic [1:0]    lamp;
      int            lat;
      logic [SW-1:0] stim;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [CW-1:0] settle = '0;
   logic [RW-1:0] resp;
   logic [SW-1:0] stim;
   logic [1:0]    lamp;
   logic          busy;
   logic          done;

   // device model fault controls: input stuck-at-1 on A or B, output stuck-at-0/1
   logic [NG-1:0]    f_a1 = '0;
   logic [NG-1:0]    f_b1 = '0;
   logic [NG-1:0]    f_y0 = '0;
   logic [NG-1:0]    f_y1 = '0;
   logic [RW-NG-1:0] junk = '0;

   int n_run = 0;
   int n_fail = 0;
   int cyc = 0;
   int t_start = 0;
   int pending = 0;
   bit finished = 1'b0;
   exp_t sbq[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   quad_gate_checker u0 (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .start_i  (start),
      .settle_i (settle),
      .resp_i   (resp),
      .stim_o   (stim),
      .lamp_o   (lamp),
      .busy_o   (busy),
      .done_o   (done)
   );

   always_comb begin
      resp = '0;
      resp[RW-1:NG] = junk;
      for (int g = 0; g < NG; g++) begin
         resp[g] = f_y0[g] ? 1'b0 :
                   f_y1[g] ? 1'b1 :
                   ~((stim[2*g] | f_a1[g]) & (stim[2*g+1] | f_b1[g]));
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   // expected verdict from the requirement tables and the fault model
   function automatic exp_t predict(input int w, input string tag);
      exp_t e;
      int n;
      logic [SW-1:0] v;
      logic [NG-1:0] y;
      logic [NG-1:0] want;
      n = 4;
      e.lamp = 2'b01;
      for (int k = 0; k < 4; k++) begin
         v = {NG{2'(k)}};
         for (int g = 0; g < NG; g++)
            y[g] = f_y0[g] ? 1'b0 : f_y1[g] ? 1'b1 :
                   ~((v[2*g] | f_a1[g]) & (v[2*g+1] | f_b1[g]));
         want = (k == 3) ? '0 : '1;
         if (y != want) begin
            n = k + 1;
            e.lamp = 2'b10;
            break;
         end
      end
      e.lat  = 1 + n * (w + 2);
      e.stim = {NG{2'(n - 1)}};
      e.tag  = tag;
      return e;
   endfunction

   // monitor: pops the scoreboard when a verdict strobe appears
   always @(negedge clk) begin
      if (rst_n && done === 1'b1) begin
         if (sbq.size() == 0) begin
            chk(1'b0, "R8", "unexpected done", 1, 0);
         end else begin
            exp_t e;
            int lat;
            e = sbq.pop_front();
            lat = cyc - t_start;
            chk(lamp === e.lamp, (e.lamp == 2'b01) ? "R5" : "R6",
                {e.tag, " lamp"}, lamp, e.lamp);
            chk(lat == e.lat, "R3", {e.tag, " verdict latency"}, lat, e.lat);
            chk(stim === e.stim, "R2", {e.tag, " last pattern"}, stim, e.stim);
            chk(busy === 1'b0, "R8", {e.tag, " busy at done"}, busy, 0);
            pending = 0;
         end
      end
   end

   task automatic run_case(input logic [CW-1:0] sv, input string tag, input bit poke);
      int w;
      exp_t e;
      logic [1:0] l0;
      w = (sv < 2) ? 2 : int'(sv);
      e = predict(w, tag);
      settle = sv;
      sbq.push_back(e);
      pending = 1;
      @(negedge clk);
      t_start = cyc;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R8", {tag, " busy after start"}, busy, 1);
      chk(lamp === 2'b00, "R7", {tag, " lamp cleared while testing"}, lamp, 0);
      if (poke) begin
         // R9: extra start in mid-run must not disturb the run
         repeat (3) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      for (int i = 0; i < 3000 && pending != 0; i++) @(negedge clk);
      if (pending != 0) begin
         chk(1'b0, "R5", {tag, " no verdict"}, 0, 1);
         pending = 0;
         sbq.delete();
      end
      l0 = lamp;
      repeat (8) @(negedge clk);
      chk(lamp === l0 && done === 1'b0 && busy === 1'b0, "R10",
          {tag, " verdict held"}, lamp, l0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "R8", "watchdog expired", 0, 1);
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(lamp === 2'b00 && busy === 1'b0 && done === 1'b0, "R1", "in reset", lamp, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(lamp === 2'b00, "R1", "lamp after reset", lamp, 0);
      chk(busy === 1'b0 && done === 1'b0, "R1", "flags after reset", {busy, done}, 0);
      chk(stim === '0, "R1", "stim after reset", stim, 0);

      // good device, settle below minimum is raised to 2
      run_case(8'd0, "R5 good settle0", 1'b0);
      // good device, noisy upper response bits
      junk = 4'hA;
      run_case(8'd5, "R4 good with junk", 1'b0);
      junk = 4'h5;
      // gate 2 output stuck high: only pattern FF exposes it
      f_y1 = 4'b0100;
      run_case(8'd3, "R6 stuck1 gate2", 1'b0);
      f_y1 = '0;
      // gate 0 output stuck low: fails on the first pattern
      f_y0 = 4'b0001;
      run_case(8'd2, "R6 stuck0 gate0", 1'b0);
      f_y0 = '0;
      // gate 1 input B stuck high: fails on pattern 55
      f_b1 = 4'b0010;
      run_case(8'd4, "R6 inB gate1", 1'b0);
      f_b1 = '0;
      // gate 3 input A stuck high: fails on pattern AA
      f_a1 = 4'b1000;
      run_case(8'd2, "R6 inA gate3", 1'b0);
      f_a1 = '0;
      // restart after fail, with a stray start mid-run
      run_case(8'd6, "R9 good poke", 1'b1);
      summary();
   end

endmodule